// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sequences the instruction fetch address so that hardware loops cost no extra cycles. It sits beside the fetch stage of a processor with a 23-bit, halfword-aligned instruction address space. The block supports two kinds of loop. A single-instruction repeat holds the fetch address on the instruction that follows the command. A block loop sends the fetch address back to the first body instruction each time the last body instruction is fetched. Each loop command carries a literal count k, and the repeated instruction or the loop body runs k+1 times.

The decoder presents each loop command together with the address of the instruction that carries it, and asserts a fetch-advance strobe when the fetch address moves on. The repeat command is one instruction word long. The block-loop command takes two words: the second word carries a signed word offset and executes as a no-op. The first body instruction is the one right after both words. The last body instruction sits at that start address plus twice the offset. The next fetch address is a combinational function of the current address and the loop state, so a redirect costs no cycle. The counters and flags change only on an advance.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, rpt_active_o, loop_active_o and hold_o are 0, and next_pc_o equals pc_i + 2 with no command present.
- R2: next_pc_o bit 0 is always 0. Bit 0 of pc_i is ignored. All address arithmetic wraps modulo 2^23.
- R3: With adv_i high and cmd_i = 2'b01 (repeat, count k), next_pc_o is pc_i + 2 and rpt_active_o is 1 from the next cycle. The following instruction is then fetched k+1 times: next_pc_o equals pc_i and hold_o is 1 for its first k fetches.
- R4: On the last fetch of the repeated instruction, next_pc_o is pc_i + 2 and hold_o is 0. rpt_active_o is 0 from the next cycle.
- R5: With adv_i high and cmd_i = 2'b10 (block loop, count k, offset n), next_pc_o is pc_i + 4 and loop_active_o is 1 from the next cycle. The loop start is pc_i + 4 and the loop end is start + 2·n, with n a signed 16-bit value.
- R6: While the loop is active, a fetch at the end address with iterations remaining gives next_pc_o equal to the loop start. The body therefore runs k+1 times in total.
- R7: On the final fetch of the end address, next_pc_o is end + 2. loop_active_o is 0 from the next cycle.
- R8: While adv_i is low, no command is taken and no counter or flag changes. next_pc_o still follows the current state.
- R9: While a repeat holds on the end address, holding takes priority over the loop redirect. The end fetch counts toward the loop only on the repeat's last fetch, and in that same cycle next_pc_o is the loop start or end + 2.
- R10: A command cycle gives next_pc_o as in R3 or R5, whatever the loop state. cmd_i = 2'b11 acts as no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 23 | Current fetch address |
| cmd_i | input | 2 | Loop command: 00 none, 01 repeat, 10 block loop, 11 none |
| count_i | input | CNT_W | Literal k of the command (k+1 passes) |
| offset_i | input | OFS_W | Signed word offset from loop start to last body instruction |
| adv_i | input | 1 | Fetch-advance strobe |
| next_pc_o | output | 23 | Next fetch address |
| hold_o | output | 1 | Address held by an active repeat |
| rpt_active_o | output | 1 | Single-instruction repeat in progress |
| loop_active_o | output | 1 | Block loop in progress |

## Verification
next_pc_o and hold_o depend combinationally on pc_i, cmd_i, adv_i and the registered state. The bench therefore checks them in the same cycle as the stimulus, 1 time unit after inputs are driven at the falling edge. The two active flags are registered and first show a change in the cycle after the advancing edge, so the bench samples them at the following falling edge. In the sweeps the bench fetches each address it computes from k and n, and compares every next address with the one that sequence calls for.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RPT  = 2'b01,
    CMD_DO   = 2'b10,
    CMD_RSV  = 2'b11
  } zol_cmd_e;
endpackage

// File: rtl/zol_rpt_ctr.sv
module zol_rpt_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  output logic             active_o,
  output logic             hold_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= cnt_i;
      act_q <= 1'b1;
    end else if (step_i && act_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else             act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
  assign hold_o   = act_q && (cnt_q != '0);
endmodule

// File: rtl/zol_blk_loop.sv
module zol_blk_loop #(
  parameter int PC_W  = 23,
  parameter int CNT_W = 14,
  parameter int OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PC_W-1:0]  start_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             active_o,
  output logic             at_end_o,
  output logic             wrap_o,
  output logic [PC_W-1:0]  start_o
);
  localparam int EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0]  start_q, end_q, span;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  // signed word offset to byte span
  assign span = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i} << 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else if (load_i) begin
      start_q <= start_i;
      end_q   <= start_i + span;
      cnt_q   <= cnt_i;
      act_q   <= 1'b1;
    end else if (step_i && at_end_o) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else             act_q <= 1'b0;
    end
  end

  assign at_end_o = act_q && (pc_i == end_q);
  assign wrap_o   = at_end_o && (cnt_q != '0);
  assign active_o = act_q;
  assign start_o  = start_q;
endmodule

// File: rtl/zol_pc_sel.sv
module zol_pc_sel #(
  parameter int PC_W = 23
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            do_i,
  input  logic            rpt_i,
  input  logic            hold_i,
  input  logic            wrap_i,
  input  logic [PC_W-1:0] start_i,
  output logic [PC_W-1:0] next_pc_o
);
  always_comb begin
    if (do_i)        next_pc_o = pc_i + PC_W'(4);
    else if (rpt_i)  next_pc_o = pc_i + PC_W'(2);
    else if (hold_i) next_pc_o = pc_i;
    else if (wrap_i) next_pc_o = start_i;
    else             next_pc_o = pc_i + PC_W'(2);
  end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int PC_W  = 23,
  parameter int CNT_W = 14,
  parameter int OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [1:0]       cmd_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic             adv_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             hold_o,
  output logic             rpt_active_o,
  output logic             loop_active_o
);
  logic [PC_W-1:0] pc_even, start_pc;
  logic            is_do, is_rpt, rpt_hold, at_end, wrap;
  logic            rpt_step, blk_step;
  logic            blk_at_end_unused;

  assign pc_even  = {pc_i[PC_W-1:1], 1'b0};
  assign is_do    = adv_i && (zol_cmd_e'(cmd_i) == CMD_DO);
  assign is_rpt   = adv_i && (zol_cmd_e'(cmd_i) == CMD_RPT);
  assign rpt_step = adv_i && !is_rpt && !is_do;
  // repeat hold stalls the loop end count
  assign blk_step = rpt_step && !rpt_hold;

  zol_rpt_ctr #(.CNT_W(CNT_W)) i_rpt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (is_rpt),
    .cnt_i    (count_i),
    .step_i   (rpt_step),
    .active_o (rpt_active_o),
    .hold_o   (rpt_hold)
  );

  zol_blk_loop #(.PC_W(PC_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) i_blk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (is_do),
    .start_i  (pc_even + PC_W'(4)),
    .ofs_i    (offset_i),
    .cnt_i    (count_i),
    .step_i   (blk_step),
    .pc_i     (pc_even),
    .active_o (loop_active_o),
    .at_end_o (blk_at_end_unused),
    .wrap_o   (wrap),
    .start_o  (start_pc)
  );

  assign at_end = blk_at_end_unused;

  zol_pc_sel #(.PC_W(PC_W)) i_sel (
    .pc_i      (pc_even),
    .do_i      (is_do),
    .rpt_i     (is_rpt),
    .hold_i    (rpt_hold),
    .wrap_i    (wrap && at_end),
    .start_i   (start_pc),
    .next_pc_o (next_pc_o)
  );

  assign hold_o = rpt_hold && !is_rpt && !is_do;
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
  parameter int PC_W = 23
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] pc_i,
  input logic [1:0]      cmd_i,
  input logic            adv_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic            hold_o,
  input logic            rpt_active_o,
  input logic            loop_active_o
);
  p_even_pc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_pc_o[0] == 1'b0);

  p_hold_same_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (next_pc_o == {pc_i[PC_W-1:1], 1'b0}));

  p_hold_needs_rpt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> rpt_active_o);

  p_rpt_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && rpt_active_o && !hold_o && cmd_i != 2'b01) |=> !rpt_active_o);

  p_do_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cmd_i == 2'b10) |=> loop_active_o);

  p_idle_loop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(loop_active_o));

  p_idle_rpt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(rpt_active_o));
endmodule

bind zol_ctrl zol_ctrl_chk #(.PC_W(PC_W)) i_chk (.*);

// File: tb/test_zol_ctrl.sv
module test_zol_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 23;
  localparam int CNT_W = 4;
  localparam int OFS_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [PC_W-1:0]  pc_i = '0;
  logic [1:0]       cmd_i = 2'b00;
  logic [CNT_W-1:0] count_i = '0;
  logic [OFS_W-1:0] offset_i = '0;
  logic             adv_i = 1'b0;
  logic [PC_W-1:0]  next_pc_o;
  logic             hold_o, rpt_active_o, loop_active_o;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  zol_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) i_zol_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check comb outputs 1 unit later, then take the edge
  task automatic step(logic [PC_W-1:0] pc, logic [1:0] cmd, int k, int n, logic a,
                      logic [PC_W-1:0] exp_pc, logic exp_hold, string req);
    @(negedge clk_i);
    pc_i = pc; cmd_i = cmd; count_i = k[CNT_W-1:0]; offset_i = n[OFS_W-1:0]; adv_i = a;
    #1;
    chk(req, 32'(next_pc_o), 32'(exp_pc));
    chk({req, " hold"}, 32'(hold_o), 32'(exp_hold));
    @(posedge clk_i);
  endtask

  task automatic flags(logic exp_r, logic exp_l, string req);
    @(negedge clk_i);
    adv_i = 1'b0; cmd_i = 2'b00;
    #1;
    chk({req, " rpt_active"}, 32'(rpt_active_o), 32'(exp_r));
    chk({req, " loop_active"}, 32'(loop_active_o), 32'(exp_l));
  endtask

  task automatic run_rpt(logic [PC_W-1:0] a, int k);
    logic [PC_W-1:0] t = a + 2;
    step(a, 2'b01, k, 0, 1'b1, t, 1'b0, "R3");
    for (int i = 0; i <= k; i++) begin
      if (i < k) step(t, 2'b00, 0, 0, 1'b1, t, 1'b1, "R3");
      else       step(t, 2'b00, 0, 0, 1'b1, t + 2, 1'b0, "R4");
    end
    flags(1'b0, 1'b0, "R4");
  endtask

  task automatic run_do(logic [PC_W-1:0] a, int k, int n);
    logic [PC_W-1:0] s = a + 4;
    logic [PC_W-1:0] addr;
    step(a, 2'b10, k, n, 1'b1, s, 1'b0, "R5");
    flags(1'b0, 1'b1, "R5");
    for (int i = 0; i <= k; i++) begin
      for (int j = 0; j <= n; j++) begin
        addr = s + PC_W'(2 * j);
        if (j < n)      step(addr, 2'b00, 0, 0, 1'b1, addr + 2, 1'b0, "R6");
        else if (i < k) step(addr, 2'b00, 0, 0, 1'b1, s, 1'b0, "R6");
        else            step(addr, 2'b00, 0, 0, 1'b1, addr + 2, 1'b0, "R7");
      end
    end
    flags(1'b0, 1'b0, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    pc_i = 23'h000120;
    #1;
    chk("R1 next", 32'(next_pc_o), 32'h122);
    chk("R1 rpt", 32'(rpt_active_o), 0);
    chk("R1 loop", 32'(loop_active_o), 0);
    chk("R1 hold", 32'(hold_o), 0);
    #(CLK_PERIOD * 2);
    rst_ni = 1'b1;
    flags(1'b0, 1'b0, "R1");

    // R2 odd input address is masked
    step(23'h000301, 2'b00, 0, 0, 1'b1, 23'h000302, 1'b0, "R2");

    // R3/R4 repeat sweep
    for (int k = 0; k < 16; k++) run_rpt(23'h001000 + PC_W'(k * 16), k);

    // R5/R6/R7 block loop sweep
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 6; n++) run_do(23'h002000 + PC_W'(k * 256 + n * 32), k, n);

    // R2 wrap at top of space: end lands on 0
    run_rpt(23'h7FFFFC, 2);
    run_do(23'h7FFFF8, 1, 2);

    // R8 adv low during repeat: no count consumed, no command taken
    step(23'h003000, 2'b01, 4, 0, 1'b1, 23'h003002, 1'b0, "R8");
    step(23'h003002, 2'b00, 0, 0, 1'b1, 23'h003002, 1'b1, "R8");
    for (int i = 0; i < 3; i++)
      step(23'h003002, 2'b10, 7, 3, 1'b0, 23'h003002, 1'b1, "R8");
    flags(1'b1, 1'b0, "R8");
    for (int i = 0; i < 3; i++)
      step(23'h003002, 2'b00, 0, 0, 1'b1, 23'h003002, 1'b1, "R8");
    step(23'h003002, 2'b00, 0, 0, 1'b1, 23'h003004, 1'b0, "R8");
    flags(1'b0, 1'b0, "R8");

    // R9 repeat on the loop end address
    step(23'h004000, 2'b10, 2, 1, 1'b1, 23'h004004, 1'b0, "R9");
    for (int i = 0; i <= 2; i++) begin
      step(23'h004004, 2'b01, 1, 0, 1'b1, 23'h004006, 1'b0, "R9");
      step(23'h004006, 2'b00, 0, 0, 1'b1, 23'h004006, 1'b1, "R9");
      step(23'h004006, 2'b00, 0, 0, 1'b1, (i < 2) ? 23'h004004 : 23'h004008, 1'b0, "R9");
    end
    flags(1'b0, 1'b0, "R9");

    // R10 reserved command acts as none; command cycle overrides redirect
    step(23'h005000, 2'b10, 2, 0, 1'b1, 23'h005004, 1'b0, "R10");
    step(23'h005004, 2'b11, 0, 0, 1'b1, 23'h005004, 1'b0, "R10");
    step(23'h005004, 2'b01, 0, 0, 1'b1, 23'h005006, 1'b0, "R10");
    flags(1'b1, 1'b1, "R10");
    step(23'h005004, 2'b00, 0, 0, 1'b1, 23'h005004, 1'b0, "R10");
    step(23'h005004, 2'b00, 0, 0, 1'b1, 23'h005006, 1'b0, "R10");
    flags(1'b0, 1'b0, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule